// File: doc/BRIEF.md
# Bus Reset Conditioner

This block sits between an active-low, asynchronous bus reset pin and the logic of a bus agent running from a 66 MHz-class clock. It produces two kinds of reset. The first is a core reset for internal flip-flops. It asserts the moment the pin goes low, and it releases only after a chain of clocked stages has filled with ones. Every flip-flop therefore leaves reset on the same clock edge, well away from a metastable window. The second is an output-enable kill. It follows the raw pin with no clock involved, so bus drivers go to high impedance at once, even if the clock has stopped.

Every stage of the release chain is cleared asynchronously by the raw pin. A low pulse of any width, at any time, empties the chain and starts the full release count again. The logic therefore never ends up with only part of its flip-flops reset. A small demonstration request state machine, a free-running counter and a request-line output enable show the behaviour at the ports.

Top module: `bus_rst_cond`

## Requirements
- R1: While `rst_in_n` is held low from power-up, `core_rst_n` is 0, `drv_kill` is 1, `req_oe` is 0, `state` is 0 (idle) and `count` is 0.
- R2: `core_rst_n` falls as soon as `rst_in_n` falls, with no clock edge in between.
- R3: `drv_kill` is the inverse of `rst_in_n` at all times, both falling and rising, with no clock edge involved.
- R4: `req_oe` is 0 whenever `rst_in_n` is low, immediately and without a clock edge.
- R5: After `rst_in_n` rises, `core_rst_n` stays 0 through the first SYNC_STAGES-1 rising clock edges and becomes 1 after edge number SYNC_STAGES.
- R6: A low pulse on `rst_in_n` of any width, including one shorter than a clock cycle, restarts the release count of R5 from the end of that pulse.
- R7: Whenever `core_rst_n` is low, `state` and `count` both hold 0. After release they leave reset on the same edge, and `count` becomes 1 on the first edge after `core_rst_n` rises.
- R8: The demo machine uses the encodings idle=0, request=1 and busy=2. From idle with `go`=1 it moves to request, then to busy, then back to idle. `req_oe` is 1 exactly in request and busy.
- R9: `count` increments by one on every edge while out of reset and wraps from 2^CNT_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_in_n | input | 1 | Raw asynchronous bus reset, active low |
| go | input | 1 | Demo request trigger |
| core_rst_n | output | 1 | Conditioned reset for internal logic, active low |
| drv_kill | output | 1 | Immediate bus output-enable kill, active high |
| req_oe | output | 1 | Request-line output enable |
| state | output | 2 | Demo machine state |
| count | output | CNT_W | Free-running demo counter |

## Verification
The bench builds the block with SYNC_STAGES=5, the depth used in practice, so the release edge is checked at the real chain length. It uses CNT_W=4 so that the counter wraps within a few dozen cycles. Glitches a few hundred picoseconds wide are placed at random distances after release, including while the demo machine is requesting. This exercises the mid-run case where a partial reset could otherwise appear.

// File: rtl/bus_rst_cond.sv
module bus_rst_cond #(
  parameter int SYNC_STAGES = 5,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_in_n,
  input  logic             go,
  output logic             core_rst_n,
  output logic             drv_kill,
  output logic             req_oe,
  output logic [1:0]       state,
  output logic [CNT_W-1:0] count
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_REQ = 2'd1, S_BUSY = 2'd2} st_t;

  logic [SYNC_STAGES-1:0] chain;
  st_t                    st;

  always_ff @(posedge clk or negedge rst_in_n)
    if (!rst_in_n) chain <= '0;
    else           chain <= {chain[SYNC_STAGES-2:0], 1'b1};

  assign core_rst_n = rst_in_n & chain[SYNC_STAGES-1];
  assign drv_kill   = ~rst_in_n;
  assign req_oe     = rst_in_n & (st != S_IDLE);
  assign state      = st;

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) st <= S_IDLE;
    else
      case (st)
        S_IDLE:  st <= go ? S_REQ : S_IDLE;
        S_REQ:   st <= S_BUSY;
        default: st <= S_IDLE;
      endcase

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) count <= '0;
    else             count <= count + 1'b1;

endmodule

// File: rtl/bus_rst_cond_chk.sv
module bus_rst_cond_chk #(
  parameter int SYNC_STAGES = 5,
  parameter int CNT_W       = 8
) (
  input logic             clk,
  input logic             rst_in_n,
  input logic             core_rst_n,
  input logic             req_oe,
  input logic [1:0]       state,
  input logic [CNT_W-1:0] count
);
  localparam int WW = $clog2(SYNC_STAGES + 1) + 1;
  logic [WW-1:0] win;

  always_ff @(posedge clk or negedge rst_in_n)
    if (!rst_in_n)                  win <= '0;
    else if (win < WW'(SYNC_STAGES)) win <= win + 1'b1;

  p_no_early_release_r5: assert property (@(posedge clk) disable iff (!rst_in_n)
    core_rst_n |-> win >= WW'(SYNC_STAGES));
  p_release_on_time_r6: assert property (@(posedge clk) disable iff (!rst_in_n)
    (win >= WW'(SYNC_STAGES)) |-> core_rst_n);
  p_req_off_in_reset_r4: assert property (@(posedge clk)
    req_oe |-> (rst_in_n && core_rst_n));
  p_reset_together_r7: assert property (@(posedge clk)
    !core_rst_n |-> (state == 2'd0 && count == '0));
  p_req_to_busy_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == 2'd1) |=> (state == 2'd2));
endmodule

bind bus_rst_cond bus_rst_cond_chk #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_in_n(rst_in_n), .core_rst_n(core_rst_n),
  .req_oe(req_oe), .state(state), .count(count));

// File: tb/sim_bus_rst_cond.sv
`timescale 1ns/10ps
module sim_bus_rst_cond;
  localparam int N = 5;
  localparam int W = 4;

  logic clk = 1'b0, rst_in_n = 1'b0, go = 1'b0;
  logic core_rst_n, drv_kill, req_oe;
  logic [1:0] state;
  logic [W-1:0] count;

  bus_rst_cond #(.SYNC_STAGES(N), .CNT_W(W)) u0 (
    .clk(clk), .rst_in_n(rst_in_n), .go(go), .core_rst_n(core_rst_n),
    .drv_kill(drv_kill), .req_oe(req_oe), .state(state), .count(count));

  always #2 clk = ~clk;

  typedef struct {
    bit core; bit kill; bit req; logic [1:0] st; logic [W-1:0] cnt; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  int rel = 0;
  logic [1:0] m_st = 2'd0;
  logic [W-1:0] m_cnt = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(core_rst_n == e.core, e.tag, "core_rst_n", core_rst_n, e.core);
      chk(drv_kill == e.kill, e.tag, "drv_kill", drv_kill, e.kill);
      chk(req_oe == e.req, e.tag, "req_oe", req_oe, e.req);
      chk(state == e.st, e.tag, "state", state, e.st);
      chk(count == e.cnt, e.tag, "count", count, e.cnt);
    end
  end

  task automatic glitch(input int w);
    #0.1 rst_in_n = 1'b0;
    #0.1;
    chk(core_rst_n == 1'b0, "R2", "core_rst_n on fall", core_rst_n, 0);
    chk(drv_kill == 1'b1, "R3", "drv_kill on fall", drv_kill, 1);
    chk(req_oe == 1'b0, "R4", "req_oe on fall", req_oe, 0);
    chk(state == 2'd0 && count == '0, "R7", "state/count together",
        {state, count}, 0);
    #(w * 0.1) rst_in_n = 1'b1;
    #0.1;
    chk(drv_kill == 1'b0, "R3", "drv_kill on rise", drv_kill, 0);
    chk(core_rst_n == 1'b0, "R6", "core_rst_n after glitch", core_rst_n, 0);
    rel = 0; m_st = 2'd0; m_cnt = '0;
  endtask

  task automatic step(input bit g_next, input string tag, input int gw = 0);
    exp_t e;
    @(posedge clk);
    if (!rst_in_n) begin
      rel = 0; m_st = 2'd0; m_cnt = '0;
    end else begin
      if (rel >= N) begin
        case (m_st)
          2'd0: m_st = go ? 2'd1 : 2'd0;
          2'd1: m_st = 2'd2;
          default: m_st = 2'd0;
        endcase
        m_cnt = m_cnt + 1'b1;
      end
      if (rel < N) rel++;
    end
    #1;
    if (gw > 0) glitch(gw);
    go = g_next;
    e.core = rst_in_n && rel >= N;
    e.kill = !rst_in_n;
    e.req  = rst_in_n && m_st != 2'd0;
    e.st   = m_st;
    e.cnt  = m_cnt;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    chk(core_rst_n == 0, "R1", "core_rst_n", core_rst_n, 0);
    chk(drv_kill == 1, "R1", "drv_kill", drv_kill, 1);
    chk(req_oe == 0, "R1", "req_oe", req_oe, 0);
    chk(state == 0 && count == 0, "R1", "state/count", {state, count}, 0);
    go = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, "R1");
    go = 1'b0;
    @(posedge clk); #1;
    rst_in_n = 1'b1;
    #0.1;
    chk(drv_kill == 0, "R3", "drv_kill on release", drv_kill, 0);
    rel = 0;
    for (int i = 0; i < 8; i++) step(1'b0, "R5");
    begin
      bit pat[10] = '{1,0,0,0,1,1,1,1,0,0};
      for (int i = 0; i < 10; i++) step(pat[i], "R8");
    end
    for (int i = 0; i < 20; i++) step(1'b0, "R9");
    for (int k = 0; k < 6; k++) begin
      int gap = $urandom_range(5, 20);
      for (int i = 0; i < gap; i++) step(1'b0, "R6");
      step(1'b0, "R7", $urandom_range(1, 5));
      for (int i = 0; i < 8; i++) step(1'b0, "R6");
    end
    for (int i = 0; i < 4; i++) step(1'b1, "R8");
    step(1'b0, "R4", 3);
    for (int i = 0; i < 7; i++) step(1'b0, "R5");
    @(posedge clk); #1;
    rst_in_n = 1'b0;
    #0.1;
    chk(core_rst_n == 0, "R2", "core_rst_n on long reset", core_rst_n, 0);
    for (int i = 0; i < 3; i++) step(1'b0, "R1");
    @(posedge clk); #1;
    rst_in_n = 1'b1;
    rel = 0; m_st = 2'd0; m_cnt = '0;
    for (int i = 0; i < 8; i++) step(1'b0, "R5");
    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule